// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block sits next to a small 32-bit processor core and carries out the register side effects of entering an interrupt at an instruction boundary. On every cycle where the core raises its boundary strobe, the sequencer looks at three kinds of request: a reset request, a non-maskable request, and six maskable request lines. It compares them with the current PC and status word (PSW), picks at most one, and in that same cycle presents the new PC, a status-word write-back and a one-cycle "taken" pulse carrying the vector. On the clock edge that closes the cycle it updates its own save registers and its cause register.

Non-maskable entry and maskable entry each have their own pair of save registers (PC and PSW) and their own half of the cause register. A non-maskable request that arrives while a non-maskable handler is already running is not lost. It is held in a one-bit deferred flag and taken later, at a boundary where nothing else is taken and the handler has finished. The core signals that the handler has finished with a pulse that clears the in-handler bit of the status word.

Top module: `irq_entry_seq`

## Requirements
- R1: After the asynchronous reset (rst_n low), the save registers, the cause register and the deferred flag all read zero, and `taken` is low.
- R2: A reset request at a boundary always wins. It gives `taken` with vector 0 and a PSW write of 0x20, and after the edge the cause register is 0 and the deferred flag is clear.
- R3: Every non-maskable or maskable entry writes a PSW with bit 5 (interrupt-disable) set and bit 6 (exception-pending) cleared.
- R4: A non-maskable request taken while PSW bit 7 (in-NMI) is clear gives vector 0x10 and a PSW write with bit 7 set. After the edge the NMI save PC and save PSW hold the incoming PC and PSW. The cause register has its upper 16 bits cleared and 0x0010 ORed into its lower 16 bits, and the deferred flag is clear.
- R5: A non-maskable request while PSW bit 7 is set is not taken. It sets the deferred flag, and any further such requests leave the flag at one. No maskable source is taken at that boundary, and the NMI save registers keep their values.
- R6: A maskable entry copies PC and PSW into the maskable save registers. It replaces the lower 16 bits of the cause register with the vector and leaves the upper 16 bits unchanged.
- R7: Maskable source i (0 to 5) has vector and cause 0x80 + 0x10·i. When several are raised, the lowest index wins, and any non-maskable or reset request beats all of them.
- R8: Maskable sources are ignored while PSW bit 5 is set. Reset and non-maskable requests are still taken.
- R9: At a boundary with no reset, no live non-maskable request and no maskable entry, a set deferred flag with PSW bit 7 clear is taken as a non-maskable entry (vector 0x10), and the flag clears.
- R10: A pulse on `np_clear` requests a PSW write with bit 7 cleared. The entry decision in that same cycle still uses the incoming bit 7, so a deferred request is taken at a later boundary.
- R11: Without the boundary strobe nothing is taken, and every save register, the cause register and the deferred flag hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boundary | input | 1 | Instruction-boundary strobe; entries are evaluated only here |
| reset_req | input | 1 | Reset entry request |
| nmi_req | input | 1 | Non-maskable request |
| irq_req | input | 6 | Maskable request lines, index 0 has top priority |
| pc_in | input | 32 | PC of the boundary |
| psw_in | input | 32 | Current status word |
| np_clear | input | 1 | Handler-return pulse that clears PSW bit 7 |
| taken | output | 1 | An entry happens in this cycle |
| taken_vec | output | 32 | New PC / vector of the entry |
| psw_we | output | 1 | PSW write enable |
| psw_wdata | output | 32 | PSW write data |
| fepc | output | 32 | NMI save PC |
| fepsw | output | 32 | NMI save PSW |
| eipc | output | 32 | Maskable save PC |
| eipsw | output | 32 | Maskable save PSW |
| ecr | output | 32 | Cause register |
| nmi_pending | output | 1 | Deferred non-maskable flag |

## Verification
Two pairs of functions can land in the same cycle. The first is a non-maskable request that meets a set in-NMI bit together with raised maskable lines: the deferral must consume the boundary. The second is the `np_clear` pulse arriving on a boundary while a request is deferred: the status write must drop bit 7, yet the deferred entry must wait for the following boundary. The bench provokes both in directed steps. It then sweeps every combination of the six lines, the non-maskable request and the two status bits, with reset and return pulses interleaved. A model built from the requirements predicts the decision, the status write and the register contents after each edge.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

  typedef enum logic [2:0] {
    ENT_NONE  = 3'd0,
    ENT_RESET = 3'd1,
    ENT_NMI   = 3'd2,
    ENT_MASK  = 3'd3,
    ENT_DEFER = 3'd4
  } entry_kind_e;

endpackage

// File: rtl/irq_entry_arb.sv
module irq_entry_arb
  import irq_entry_pkg::*;
#(
  parameter int NSRC = 6,
  localparam int IDXW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boundary,
  input  logic              reset_req,
  input  logic              nmi_req,
  input  logic [NSRC-1:0]   irq_req,
  input  logic              psw_id,
  input  logic              psw_np,
  input  logic              pend,
  output entry_kind_e       kind,
  output logic [IDXW-1:0]   src_idx
);

  logic [NSRC-1:0] grant;

  // fixed priority, lowest index first
  genvar gi;
  generate
    for (gi = 0; gi < NSRC; gi++) begin : g_grant
      if (gi == 0) begin : g_first
        assign grant[gi] = irq_req[gi];
      end else begin : g_rest
        assign grant[gi] = irq_req[gi] & ~(|irq_req[gi-1:0]);
      end
    end
  endgenerate

  always_comb begin
    src_idx = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (grant[i]) src_idx = IDXW'(i);
    end
  end

  always_comb begin
    kind = ENT_NONE;
    if (boundary) begin
      if (reset_req)                 kind = ENT_RESET;
      else if (nmi_req && !psw_np)   kind = ENT_NMI;
      else if (nmi_req)              kind = ENT_DEFER;
      else if (!psw_id && |irq_req)  kind = ENT_MASK;
      else if (pend && !psw_np)      kind = ENT_NMI;
    end
  end

  // R7
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R8
  mask_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == ENT_MASK) |-> (!psw_id && !reset_req && !nmi_req));

  // R5
  nmi_np_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == ENT_NMI) |-> !psw_np);

endmodule

// File: rtl/irq_entry_bank.sv
module irq_entry_bank
  import irq_entry_pkg::*;
#(
  parameter int          XLEN    = 32,
  parameter logic [15:0] NMI_CAUSE = 16'h0010,
  localparam int         HALF    = XLEN / 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  entry_kind_e     kind,
  input  logic [XLEN-1:0] pc_in,
  input  logic [XLEN-1:0] psw_in,
  input  logic [XLEN-1:0] mask_vec,
  output logic [XLEN-1:0] fepc,
  output logic [XLEN-1:0] fepsw,
  output logic [XLEN-1:0] eipc,
  output logic [XLEN-1:0] eipsw,
  output logic [XLEN-1:0] ecr,
  output logic            pend
);

  logic [XLEN-1:0] fepc_nx, fepsw_nx, eipc_nx, eipsw_nx, ecr_nx;
  logic            pend_nx;
  logic            nmi_en, mask_en, ecr_en, pend_en;

  assign nmi_en  = (kind == ENT_NMI);
  assign mask_en = (kind == ENT_MASK);
  assign ecr_en  = nmi_en | mask_en | (kind == ENT_RESET);
  assign pend_en = nmi_en | (kind == ENT_RESET) | (kind == ENT_DEFER);

  always_comb begin
    fepc_nx  = pc_in;
    fepsw_nx = psw_in;
    eipc_nx  = pc_in;
    eipsw_nx = psw_in;
    pend_nx  = (kind == ENT_DEFER);
    unique case (kind)
      ENT_RESET: ecr_nx = '0;
      ENT_NMI:   ecr_nx = {{HALF{1'b0}}, ecr[HALF-1:0] | HALF'(NMI_CAUSE)};
      ENT_MASK:  ecr_nx = {ecr[XLEN-1:HALF], mask_vec[HALF-1:0]};
      default:   ecr_nx = ecr;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fepc  <= '0;
      fepsw <= '0;
    end else if (nmi_en) begin
      fepc  <= fepc_nx;
      fepsw <= fepsw_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eipc  <= '0;
      eipsw <= '0;
    end else if (mask_en) begin
      eipc  <= eipc_nx;
      eipsw <= eipsw_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ecr <= '0;
    else if (ecr_en) ecr <= ecr_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend <= 1'b0;
    else if (pend_en) pend <= pend_nx;
  end

  // R4
  fepc_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == ENT_NMI) |=> (fepc == $past(pc_in) && fepsw == $past(psw_in) && !pend));

  // R5
  defer_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == ENT_DEFER) |=> (pend && $stable(fepc)));

  // R6
  ecr_lower_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == ENT_MASK) |=> (ecr[HALF-1:0] == $past(mask_vec[HALF-1:0])));

  // R2
  reset_ecr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == ENT_RESET) |=> (ecr == '0 && !pend));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == ENT_NONE) |=> ($stable(ecr) && $stable(eipc) && $stable(fepc) && $stable(pend)));

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
#(
  parameter int          XLEN      = 32,
  parameter int          NSRC      = 6,
  parameter logic [31:0] VEC_BASE  = 32'h80,
  parameter logic [31:0] VEC_STEP  = 32'h10,
  parameter logic [31:0] NMI_VEC   = 32'h10,
  parameter logic [31:0] RST_VEC   = 32'h0,
  parameter logic [31:0] RST_PSW   = 32'h20,
  parameter int          ID_BIT    = 5,
  parameter int          EP_BIT    = 6,
  parameter int          NP_BIT    = 7,
  localparam int         IDXW      = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            boundary,
  input  logic            reset_req,
  input  logic            nmi_req,
  input  logic [NSRC-1:0] irq_req,
  input  logic [XLEN-1:0] pc_in,
  input  logic [XLEN-1:0] psw_in,
  input  logic            np_clear,
  output logic            taken,
  output logic [XLEN-1:0] taken_vec,
  output logic            psw_we,
  output logic [XLEN-1:0] psw_wdata,
  output logic [XLEN-1:0] fepc,
  output logic [XLEN-1:0] fepsw,
  output logic [XLEN-1:0] eipc,
  output logic [XLEN-1:0] eipsw,
  output logic [XLEN-1:0] ecr,
  output logic            nmi_pending
);

  entry_kind_e     kind;
  logic [IDXW-1:0] src_idx;
  logic [XLEN-1:0] mask_vec;
  logic [XLEN-1:0] psw_base;

  irq_entry_arb #(.NSRC(NSRC)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .boundary  (boundary),
    .reset_req (reset_req),
    .nmi_req   (nmi_req),
    .irq_req   (irq_req),
    .psw_id    (psw_in[ID_BIT]),
    .psw_np    (psw_in[NP_BIT]),
    .pend      (nmi_pending),
    .kind      (kind),
    .src_idx   (src_idx)
  );

  assign mask_vec = XLEN'(VEC_BASE) + XLEN'(src_idx) * XLEN'(VEC_STEP);

  irq_entry_bank #(.XLEN(XLEN), .NMI_CAUSE(NMI_VEC[15:0])) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .kind     (kind),
    .pc_in    (pc_in),
    .psw_in   (psw_in),
    .mask_vec (mask_vec),
    .fepc     (fepc),
    .fepsw    (fepsw),
    .eipc     (eipc),
    .eipsw    (eipsw),
    .ecr      (ecr),
    .pend     (nmi_pending)
  );

  always_comb begin
    psw_base = psw_in;
    if (np_clear) psw_base[NP_BIT] = 1'b0;
  end

  always_comb begin
    taken     = 1'b0;
    taken_vec = '0;
    psw_wdata = psw_base;
    unique case (kind)
      ENT_RESET: begin
        taken     = 1'b1;
        taken_vec = XLEN'(RST_VEC);
        psw_wdata = XLEN'(RST_PSW);
      end
      ENT_NMI: begin
        taken             = 1'b1;
        taken_vec         = XLEN'(NMI_VEC);
        psw_wdata[ID_BIT] = 1'b1;
        psw_wdata[EP_BIT] = 1'b0;
        psw_wdata[NP_BIT] = 1'b1;
      end
      ENT_MASK: begin
        taken             = 1'b1;
        taken_vec         = mask_vec;
        psw_wdata[ID_BIT] = 1'b1;
        psw_wdata[EP_BIT] = 1'b0;
      end
      default: ;
    endcase
  end

  assign psw_we = taken | np_clear;

  // R11
  taken_needs_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    taken |-> boundary);

  // R3
  entry_psw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && !reset_req) |-> (psw_we && psw_wdata[ID_BIT] && !psw_wdata[EP_BIT]));

  // R10
  npclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (np_clear && !taken) |-> (psw_we && !psw_wdata[NP_BIT]));

  // R9
  pend_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_pending && boundary && !reset_req && !nmi_req && !psw_in[NP_BIT]
     && (psw_in[ID_BIT] || irq_req == '0)) |-> (taken && taken_vec == XLEN'(NMI_VEC)));

endmodule

// File: tb/test_irq_entry_seq.sv
module test_irq_entry_seq;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        boundary, reset_req, nmi_req, np_clear;
  logic [5:0]  irq_req;
  logic [31:0] pc_in, psw_in;
  logic        taken, psw_we, nmi_pending;
  logic [31:0] taken_vec, psw_wdata, fepc, fepsw, eipc, eipsw, ecr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // model state
  logic [31:0] m_fepc, m_fepsw, m_eipc, m_eipsw, m_ecr;
  logic        m_pend;

  always #4 clk = ~clk;

  irq_entry_seq i_irq_entry_seq (
    .clk(clk), .rst_n(rst_n), .boundary(boundary), .reset_req(reset_req),
    .nmi_req(nmi_req), .irq_req(irq_req), .pc_in(pc_in), .psw_in(psw_in),
    .np_clear(np_clear), .taken(taken), .taken_vec(taken_vec), .psw_we(psw_we),
    .psw_wdata(psw_wdata), .fepc(fepc), .fepsw(fepsw), .eipc(eipc),
    .eipsw(eipsw), .ecr(ecr), .nmi_pending(nmi_pending)
  );

  task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  task automatic chk_regs(string tag);
    chk(tag, "fepc", fepc, m_fepc);
    chk(tag, "fepsw", fepsw, m_fepsw);
    chk(tag, "eipc", eipc, m_eipc);
    chk(tag, "eipsw", eipsw, m_eipsw);
    chk(tag, "ecr", ecr, m_ecr);
    chk(tag, "pending", {31'b0, nmi_pending}, {31'b0, m_pend});
  endtask

  // kinds: 0 none, 1 reset, 2 nmi, 3 maskable, 4 deferred
  task automatic step(string tag, bit bnd, bit rst, bit nmi, logic [5:0] irq,
                      logic [31:0] pc, logic [31:0] psw, bit npclr);
    int          kind;
    int          idx;
    logic [31:0] vec, pw, base;
    bit          id, np;
    @(negedge clk);
    chk_regs(tag);
    boundary = bnd; reset_req = rst; nmi_req = nmi; irq_req = irq;
    pc_in = pc; psw_in = psw; np_clear = npclr;
    #1;
    id = psw[5]; np = psw[7];
    idx = 0;
    for (int i = 5; i >= 0; i--) if (irq[i]) idx = i;
    kind = 0;
    if (bnd) begin
      if (rst)                     kind = 1;
      else if (nmi && !np)         kind = 2;
      else if (nmi)                kind = 4;
      else if (!id && irq != 6'd0) kind = 3;
      else if (m_pend && !np)      kind = 2;
    end
    base = npclr ? (psw & ~32'h80) : psw;
    vec = 32'h0;
    pw  = base;
    case (kind)
      1: begin vec = 32'h0; pw = 32'h20; end
      2: begin vec = 32'h10; pw = (base | 32'ha0) & ~32'h40; end
      3: begin vec = 32'h80 + 32'h10 * idx; pw = (base | 32'h20) & ~32'h40; end
      default: ;
    endcase
    chk(tag, "taken", {31'b0, taken}, {31'b0, (kind >= 1 && kind <= 3)});
    if (kind >= 1 && kind <= 3) chk(tag, "vector", taken_vec, vec);
    chk(tag, "psw_we", {31'b0, psw_we}, {31'b0, (kind >= 1 && kind <= 3) || npclr});
    if (psw_we) chk(tag, "psw_wdata", psw_wdata, pw);
    case (kind)
      1: begin m_ecr = 32'h0; m_pend = 1'b0; end
      2: begin
        m_fepc = pc; m_fepsw = psw;
        m_ecr  = {16'h0, m_ecr[15:0] | 16'h0010};
        m_pend = 1'b0;
      end
      3: begin m_eipc = pc; m_eipsw = psw; m_ecr = {m_ecr[31:16], vec[15:0]}; end
      4: m_pend = 1'b1;
      default: ;
    endcase
  endtask

  initial begin
    #(8 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0;
    boundary = 0; reset_req = 0; nmi_req = 0; irq_req = '0;
    pc_in = '0; psw_in = '0; np_clear = 0;
    m_fepc = '0; m_fepsw = '0; m_eipc = '0; m_eipsw = '0; m_ecr = '0; m_pend = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "taken at reset", {31'b0, taken}, 32'h0);
    rst_n = 1'b1;
    // R1 register state checked at the first step
    step("R1", 0, 0, 0, 6'h00, 32'h100, 32'h0, 0);
    // R2 reset wins over everything
    step("R2", 1, 1, 1, 6'h3f, 32'h200, 32'h0, 0);
    // R4 NMI with NP clear
    step("R4", 1, 0, 1, 6'h00, 32'h300, 32'h0000_0040, 0);
    // R5 NMI while NP set: deferred, maskable blocked this boundary
    step("R5", 1, 0, 1, 6'h04, 32'h304, 32'h0000_0080, 0);
    step("R5", 1, 0, 1, 6'h00, 32'h308, 32'h0000_00a0, 0);
    // R10 return pulse on a boundary: still deferred this cycle
    step("R10", 1, 0, 0, 6'h00, 32'h30c, 32'h0000_00a0, 1);
    // R9 maskable goes before the deferred NMI
    step("R9", 1, 0, 0, 6'h02, 32'h400, 32'h0000_0000, 0);
    step("R9", 1, 0, 0, 6'h00, 32'h500, 32'h0000_0020, 0);
    // R8 maskable ignored with ID set, NMI still taken
    step("R8", 1, 0, 0, 6'h3f, 32'h600, 32'h0000_0020, 0);
    step("R8", 1, 0, 1, 6'h3f, 32'h604, 32'h0000_0020, 0);
    // R6 each source alone
    for (int s = 0; s < 6; s++)
      step("R6", 1, 0, 0, 6'(1 << s), 32'h700 + 32'(s) * 4, 32'h1234_0000, 0);
    // R11 everything raised without the strobe
    step("R11", 0, 1, 1, 6'h3f, 32'h800, 32'h0, 1);
    step("R11", 0, 0, 0, 6'h00, 32'h804, 32'h0, 0);
    // R7 near-exhaustive sweep
    for (int k = 0; k < 1024; k++) begin
      logic [31:0] p;
      p = (32'(k) * 32'h9e37_79b1) & ~32'he0;
      p = p | (32'(k[7]) << 5) | (32'(k[0]) << 6) | (32'(k[8]) << 7);
      step("R7", (k % 13) != 7, (k % 37) == 5, k[6], k[5:0],
           32'h1000 + 32'(k) * 4, p, (k % 11) == 3);
    end
    @(negedge clk);
    chk_regs("R7");
    summary();
  end

endmodule